// File: doc/BRIEF.md
# Sound Unit Register Bank with Power Gating

This block is the byte-wide register front end of a four-channel sound unit. A CPU reads and writes it through a small address window. The window holds twenty channel and mixer registers, a master power register, and a 16-byte waveform RAM used by the wave channel. The block stores each register value and returns it on reads. Bits that have no storage read back as one. Each accepted write to a register is passed downstream as a one-cycle strobe that carries the byte.

Writes are gated by the master power bit. When power is off, channel and mixer writes store zero and raise no strobe. A legacy compatibility input keeps a few exceptions alive in that state. Waveform RAM access follows the wave channel's playback state. While the channel plays, an access may be redirected to the byte being played, or blocked. The channel logic supplies its playback position, its readable-window flag and the four channel-active bits.

Top module: `snd_regbank`

## Requirements
- R1: After reset, rd_data is 0x00 and no strobe is raised. Register reads then return: power register 0xF0 ORed with ch_active, offset 0x12 0x77, offset 0x13 0xF3, offset 0x00 0x80, offset 0x09 0x7F, offset 0x0B 0x9F. All other channel registers hold zero.
- R2: A read of channel register offset k returns the stored byte ORed with a fixed mask. The masks are: 0x80 at 0x00; 0x3F at 0x01 and 0x05; 0x00 at 0x02, 0x06, 0x0F, 0x10, 0x12 and 0x13; 0xFF at 0x03, 0x07, 0x0A, 0x0C and 0x0E; 0xBF at 0x04, 0x08, 0x0D and 0x11; 0x7F at 0x09; 0x9F at 0x0B.
- R3: The power register sits at offset 0x14. A write stores only bit 7 and always raises strobe bit 20 with the full byte. A read returns bit 7 as the power state, bits 6..4 as ones and bits 3..0 as ch_active.
- R4: With power on, a write to channel offset k (0x00..0x13) stores the byte. In the next cycle, wr_stb has only bit k set and wr_stb_data equals the byte.
- R5: With power off and legacy_mode low, a write to offsets 0x00..0x13 stores zero and raises no strobe.
- R6: With power off and legacy_mode high, writes to the wave length register (0x0A) and the noise length register (0x0E) are stored and strobed as if power were on.
- R7: With power off and legacy_mode high, a write to pulse length offset 0x01 or 0x05 stores zero. It still raises that register's strobe, with wr_stb_data equal to the byte ANDed with 0x3F.
- R8: Offsets 0x15..0x1F and 0x30..0x3F read 0xFF. Writes to them change nothing and raise no strobe.
- R9: While wave_playing is low, offsets 0x20..0x2F read and write waveform byte (offset − 0x20) directly, whatever the power state.
- R10: While wave_playing and legacy_mode are high and wave_readable is low, waveform reads return 0xFF and waveform writes are dropped.
- R11: While wave_playing, legacy_mode and wave_readable are high, any waveform read or write uses byte wave_pos>>1, regardless of the address.
- R12: While wave_playing is high and legacy_mode is low, waveform reads return byte wave_pos>>1 and writes use the addressed byte.
- R13: rd_data shows the result of a read in the cycle after bus_rd and holds it until the next read. A strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte offset inside the bank |
| bus_wr | input | 1 | Write request, one cycle per byte |
| bus_rd | input | 1 | Read request, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| legacy_mode | input | 1 | Selects the legacy compatibility rules |
| ch_active | input | 4 | Channel-active status bits shown in the power register |
| wave_playing | input | 1 | Wave channel is currently playing |
| wave_readable | input | 1 | Wave channel is inside its access window |
| wave_pos | input | $clog2(WAVE_DEPTH)+1 (5) | Current 4-bit sample index of the wave channel |
| rd_data | output | 8 | Registered read data |
| wr_stb | output | 21 | One-hot per-register write strobe, bit = register offset |
| wr_stb_data | output | 8 | Byte forwarded with the strobe, zero when none |

## Verification
A wrong power bit shows up in the very next write. A stored write that should have been zeroed appears in the following read as the wrong byte. A strobe that should have been suppressed, or that carries the wrong data, is visible one cycle after the write. A wrong redirect in the waveform path surfaces as a wrong byte in the cycle after a read. A misplaced write stays hidden until that byte is read back with playback stopped. For that reason, every redirect case is followed by direct readbacks of both the addressed byte and the played byte.

// File: rtl/snd_regbank_pkg.sv
`timescale 1ns/1ps
package snd_regbank_pkg;
  localparam int DW    = 8;
  localparam int NCH   = 4;
  localparam int NCREG = 20;          // channel and mixer registers
  localparam int NREG  = NCREG + 1;   // plus the power register

  localparam int unsigned R_SWEEP = 0;
  localparam int unsigned R_P1LEN = 1;
  localparam int unsigned R_P1ENV = 2;
  localparam int unsigned R_P1FLO = 3;
  localparam int unsigned R_P1CTL = 4;
  localparam int unsigned R_P2LEN = 5;
  localparam int unsigned R_P2ENV = 6;
  localparam int unsigned R_P2FLO = 7;
  localparam int unsigned R_P2CTL = 8;
  localparam int unsigned R_WEN   = 9;
  localparam int unsigned R_WLEN  = 10;
  localparam int unsigned R_WLVL  = 11;
  localparam int unsigned R_WFLO  = 12;
  localparam int unsigned R_WCTL  = 13;
  localparam int unsigned R_NLEN  = 14;
  localparam int unsigned R_NENV  = 15;
  localparam int unsigned R_NPOLY = 16;
  localparam int unsigned R_NCTL  = 17;
  localparam int unsigned R_VOL   = 18;
  localparam int unsigned R_PAN   = 19;
  localparam int unsigned R_PWR   = 20;

  localparam logic [DW-1:0] LEN_KEEP = 8'h3F;

  // bits with no storage, forced high on reads
  function automatic logic [DW-1:0] rd_mask(input int unsigned i);
    case (i)
      R_SWEEP:                                 rd_mask = 8'h80;
      R_P1LEN, R_P2LEN:                        rd_mask = 8'h3F;
      R_P1FLO, R_P2FLO, R_WFLO, R_WLEN, R_NLEN: rd_mask = 8'hFF;
      R_P1CTL, R_P2CTL, R_WCTL, R_NCTL:        rd_mask = 8'hBF;
      R_WEN:                                   rd_mask = 8'h7F;
      R_WLVL:                                  rd_mask = 8'h9F;
      default:                                 rd_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] rst_val(input int unsigned i);
    case (i)
      R_SWEEP: rst_val = 8'h80;
      R_WEN:   rst_val = 8'h7F;
      R_WLVL:  rst_val = 8'h9F;
      R_VOL:   rst_val = 8'h77;
      R_PAN:   rst_val = 8'hF3;
      default: rst_val = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/snd_reg_file.sv
`timescale 1ns/1ps
module snd_reg_file
  import snd_regbank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              legacy,
  input  logic [NCH-1:0]    ch_active,
  output logic [DW-1:0]     rd_val,
  output logic              pwr_on,
  output logic [NREG-1:0]   stb,
  output logic [DW-1:0]     stb_data
);
  logic [DW-1:0] regs [NCREG];
  logic          chan_hit, pwr_hit;
  logic          store_en, stb_en;
  logic [DW-1:0] store_val, stb_val;
  logic          len_exempt, pulse_len;
  logic [NREG-1:0] one_hot;

  assign chan_hit   = addr < ADDR_W'(NCREG);
  assign pwr_hit    = addr == ADDR_W'(R_PWR);
  assign len_exempt = (addr == ADDR_W'(R_WLEN)) || (addr == ADDR_W'(R_NLEN));
  assign pulse_len  = (addr == ADDR_W'(R_P1LEN)) || (addr == ADDR_W'(R_P2LEN));
  assign one_hot    = NREG'(1) << addr;

  // write gating by power state and compatibility mode
  always_comb begin
    store_en  = wr && chan_hit;
    store_val = '0;
    stb_en    = 1'b0;
    stb_val   = '0;
    if (pwr_on || (legacy && len_exempt)) begin
      store_val = wdata;
      stb_en    = store_en;
      stb_val   = wdata;
    end else if (legacy && pulse_len) begin
      stb_en  = store_en;
      stb_val = wdata & LEN_KEEP;
    end
  end

  for (genvar g = 0; g < NCREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= rst_val(g);
      else if (store_en && addr == ADDR_W'(g))
        regs[g] <= store_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      pwr_on <= 1'b1;
    else if (wr && pwr_hit)
      pwr_on <= wdata[DW-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb      <= '0;
      stb_data <= '0;
    end else if ((stb_en) || (wr && pwr_hit)) begin
      stb      <= one_hot;
      stb_data <= pwr_hit ? wdata : stb_val;
    end else begin
      stb      <= '0;
      stb_data <= '0;
    end
  end

  always_comb begin
    rd_val = 8'hFF;
    if (pwr_hit)
      rd_val = {pwr_on, 3'b111, ch_active};
    for (int i = 0; i < NCREG; i++)
      if (addr == ADDR_W'(i))
        rd_val = regs[i] | rd_mask(i);
  end
endmodule

// File: rtl/snd_wave_port.sv
`timescale 1ns/1ps
module snd_wave_port #(
  parameter int ADDR_W     = 6,
  parameter int WAVE_BASE  = 32,
  parameter int WAVE_DEPTH = 16,
  localparam int WAW   = $clog2(WAVE_DEPTH),
  localparam int POS_W = WAW + 1
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              legacy,
  input  logic              playing,
  input  logic              readable,
  input  logic [POS_W-1:0]  pos,
  output logic              hit,
  output logic              ram_we,
  output logic [WAW-1:0]    waddr,
  output logic              ram_re,
  output logic [WAW-1:0]    raddr
);
  logic [WAW-1:0] off, cur;
  logic           direct, locked;

  assign hit    = (addr >= ADDR_W'(WAVE_BASE)) &&
                  (addr <  ADDR_W'(WAVE_BASE + WAVE_DEPTH));
  assign off    = WAW'(addr - ADDR_W'(WAVE_BASE));
  assign cur    = WAW'(pos >> 1);
  assign direct = !playing || !legacy;
  assign locked = playing && legacy && !readable;

  assign ram_we = wr && hit && !locked;
  assign waddr  = direct ? off : cur;
  assign ram_re = rd && hit && !locked;
  assign raddr  = playing ? cur : off;
endmodule

// File: rtl/snd_wave_ram.sv
`timescale 1ns/1ps
module snd_wave_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (we) mem[waddr] <= wdata;

  always_ff @(posedge clk)
    if (re) q <= mem[raddr];
endmodule

// File: rtl/snd_regbank.sv
`timescale 1ns/1ps
module snd_regbank
  import snd_regbank_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int WAVE_BASE  = 32,
  parameter int WAVE_DEPTH = 16,
  localparam int POS_W     = $clog2(WAVE_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              legacy_mode,
  input  logic [3:0]        ch_active,
  input  logic              wave_playing,
  input  logic              wave_readable,
  input  logic [POS_W-1:0]  wave_pos,
  output logic [7:0]        rd_data,
  output logic [20:0]       wr_stb,
  output logic [7:0]        wr_stb_data
);
  localparam int WAW = $clog2(WAVE_DEPTH);

  logic [DW-1:0]  reg_rd_val, ram_q, rd_reg_q;
  logic           pwr_on, wave_hit, ram_we, ram_re, rd_from_ram;
  logic [WAW-1:0] ram_waddr, ram_raddr;

  snd_reg_file #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .legacy(legacy_mode), .ch_active(ch_active), .rd_val(reg_rd_val),
    .pwr_on(pwr_on), .stb(wr_stb), .stb_data(wr_stb_data)
  );

  snd_wave_port #(.ADDR_W(ADDR_W), .WAVE_BASE(WAVE_BASE), .WAVE_DEPTH(WAVE_DEPTH)) u_wport (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .legacy(legacy_mode),
    .playing(wave_playing), .readable(wave_readable), .pos(wave_pos),
    .hit(wave_hit), .ram_we(ram_we), .waddr(ram_waddr),
    .ram_re(ram_re), .raddr(ram_raddr)
  );

  snd_wave_ram #(.DEPTH(WAVE_DEPTH), .DW(DW)) u_wram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(bus_wdata),
    .re(ram_re), .raddr(ram_raddr), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg_q    <= '0;
      rd_from_ram <= 1'b0;
    end else if (bus_rd) begin
      rd_from_ram <= ram_re;
      rd_reg_q    <= wave_hit ? 8'hFF : reg_rd_val;
    end
  end

  assign rd_data = rd_from_ram ? ram_q : rd_reg_q;
endmodule

// File: rtl/snd_regbank_chk.sv
`timescale 1ns/1ps
module snd_regbank_chk
  import snd_regbank_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int WAVE_BASE  = 32,
  parameter int WAVE_DEPTH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic              legacy_mode,
  input logic              wave_playing,
  input logic              wave_readable,
  input logic [7:0]        rd_data,
  input logic [20:0]       wr_stb,
  input logic [7:0]        wr_stb_data,
  input logic              pwr_on
);
  logic in_wave, unmapped, pulse_len;
  assign in_wave   = (bus_addr >= ADDR_W'(WAVE_BASE)) &&
                     (bus_addr <  ADDR_W'(WAVE_BASE + WAVE_DEPTH));
  assign unmapped  = (bus_addr > ADDR_W'(R_PWR)) && !in_wave;
  assign pulse_len = (bus_addr == ADDR_W'(R_P1LEN)) || (bus_addr == ADDR_W'(R_P2LEN));

  assert_stb_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb));

  assert_off_no_stb_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !pwr_on && !legacy_mode && bus_addr < ADDR_W'(R_PWR)) |=> (wr_stb == '0));

  assert_pulse_fwd_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !pwr_on && legacy_mode && pulse_len) |=>
      (wr_stb_data == ($past(bus_wdata) & 8'h3F)));

  assert_unmapped_wr_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && unmapped) |=> (wr_stb == '0));

  assert_unmapped_rd_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> (rd_data == 8'hFF));

  assert_pwr_read_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(R_PWR)) |=>
      (rd_data[6:4] == 3'b111 && rd_data[7] == $past(pwr_on)));

  assert_wave_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_wave && wave_playing && legacy_mode && !wave_readable) |=>
      (rd_data == 8'hFF));

  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rd_data));
endmodule

bind snd_regbank snd_regbank_chk #(
  .ADDR_W(ADDR_W), .WAVE_BASE(WAVE_BASE), .WAVE_DEPTH(WAVE_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .legacy_mode(legacy_mode), .wave_playing(wave_playing),
  .wave_readable(wave_readable), .rd_data(rd_data), .wr_stb(wr_stb),
  .wr_stb_data(wr_stb_data), .pwr_on(pwr_on)
);

// File: tb/snd_regbank_test.sv
`timescale 1ns/1ps
module snd_regbank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        legacy_mode = 1'b0;
  logic [3:0]  ch_active = 4'b0001;
  logic        wave_playing = 1'b0, wave_readable = 1'b0;
  logic [4:0]  wave_pos = '0;
  logic [7:0]  rd_data, wr_stb_data;
  logic [20:0] wr_stb;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  logic [7:0]  m_reg [20];
  logic        m_pwr;
  logic [7:0]  m_wave [16];
  logic [7:0]  e_rd = 8'h00, e_sd = 8'h00;
  logic [20:0] e_stb = '0;

  always #2.5 clk = ~clk;

  snd_regbank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .legacy_mode(legacy_mode), .ch_active(ch_active),
    .wave_playing(wave_playing), .wave_readable(wave_readable), .wave_pos(wave_pos),
    .rd_data(rd_data), .wr_stb(wr_stb), .wr_stb_data(wr_stb_data)
  );

  function automatic logic [7:0] b_mask(input int a);
    case (a)
      0: return 8'h80;
      1, 5: return 8'h3F;
      3, 7, 10, 12, 14: return 8'hFF;
      4, 8, 13, 17: return 8'hBF;
      9: return 8'h7F;
      11: return 8'h9F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model(input bit wr, input bit rd, input int a, input logic [7:0] d);
    bit wave = (a >= 32 && a < 48);
    int cur = int'(wave_pos) >> 1;
    if (rd) begin
      if (wave) begin
        if (!wave_playing) e_rd = m_wave[a-32];
        else if (legacy_mode && !wave_readable) e_rd = 8'hFF;
        else e_rd = m_wave[cur];
      end else if (a < 20) e_rd = m_reg[a] | b_mask(a);
      else if (a == 20) e_rd = {m_pwr, 3'b111, ch_active};
      else e_rd = 8'hFF;
    end
    e_stb = '0; e_sd = '0;
    if (wr) begin
      if (wave) begin
        if (!wave_playing || !legacy_mode) m_wave[a-32] = d;
        else if (wave_readable) m_wave[cur] = d;
      end else if (a == 20) begin
        m_pwr = d[7]; e_stb[20] = 1'b1; e_sd = d;
      end else if (a < 20) begin
        if (m_pwr || (legacy_mode && (a == 10 || a == 14))) begin
          m_reg[a] = d; e_stb[a] = 1'b1; e_sd = d;
        end else if (legacy_mode && (a == 1 || a == 5)) begin
          m_reg[a] = 8'h00; e_stb[a] = 1'b1; e_sd = d & 8'h3F;
        end else m_reg[a] = 8'h00;
      end
    end
  endtask

  task automatic cyc(input bit wr, input bit rd, input int a, input logic [7:0] d, input string tag);
    bus_wr = wr; bus_rd = rd; bus_addr = 6'(a); bus_wdata = d;
    @(posedge clk);
    model(wr, rd, a, d);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check(tag, "rd_data", 32'(rd_data), 32'(e_rd));
    check(tag, "wr_stb", 32'(wr_stb), 32'(e_stb));
    check(tag, "wr_stb_data", 32'(wr_stb_data), 32'(e_sd));
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1'b0, 1'b1, a, 8'h00, tag);
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string tag);
    cyc(1'b1, 1'b0, a, d, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_pwr = 1'b1;
    for (int i = 0; i < 20; i++) m_reg[i] = 8'h00;
    m_reg[0] = 8'h80; m_reg[9] = 8'h7F; m_reg[11] = 8'h9F;
    m_reg[18] = 8'h77; m_reg[19] = 8'hF3;
    for (int i = 0; i < 16; i++) m_wave[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "reset rd_data", 32'(rd_data), 32'h00);
    check("R1", "reset wr_stb", 32'(wr_stb), 32'h0);
    // R1 reset values
    rd(20, "R1"); rd(18, "R1"); rd(19, "R1"); rd(0, "R1"); rd(9, "R1"); rd(11, "R1"); rd(2, "R1");
    // R4 power-on writes, then R2 readback masks
    for (int a = 0; a < 20; a++) wr(a, 8'h5A ^ 8'(a * 7), "R4");
    for (int a = 0; a < 20; a++) rd(a, "R2");
    // R13 hold and one-cycle strobe
    wr(3, 8'h12, "R13");
    cyc(1'b0, 1'b0, 0, 8'h00, "R13");
    rd(3, "R13");
    cyc(1'b0, 1'b0, 0, 8'h00, "R13");
    cyc(1'b0, 1'b0, 5, 8'h00, "R13");
    // R3 power register
    ch_active = 4'b1010;
    wr(20, 8'hFF, "R3"); rd(20, "R3");
    // R8 unmapped
    wr(21, 8'h11, "R8"); wr(31, 8'h22, "R8"); wr(48, 8'h33, "R8"); wr(63, 8'h44, "R8");
    rd(21, "R8"); rd(31, "R8"); rd(48, "R8"); rd(63, "R8"); rd(1, "R8");
    // power off, strict mode
    wr(20, 8'h7F, "R3"); rd(20, "R3");
    for (int a = 0; a < 20; a++) wr(a, 8'hFF, "R5");
    for (int a = 0; a < 20; a++) rd(a, "R5");
    // legacy exceptions while off
    legacy_mode = 1'b1;
    wr(10, 8'h3C, "R6"); wr(14, 8'h5A, "R6"); rd(10, "R6"); rd(14, "R6");
    wr(1, 8'hFF, "R7"); wr(5, 8'hC5, "R7"); rd(1, "R7"); rd(5, "R7");
    wr(2, 8'hAA, "R5"); rd(2, "R5");
    // R9 wave RAM reachable while off
    wr(35, 8'h77, "R9"); rd(35, "R9");
    wr(20, 8'h80, "R3"); rd(20, "R3");
    legacy_mode = 1'b0;
    for (int i = 0; i < 16; i++) wr(32 + i, 8'h10 + 8'(i * 9), "R9");
    for (int i = 0; i < 16; i++) rd(32 + i, "R9");
    // R10 locked access
    legacy_mode = 1'b1; wave_playing = 1'b1; wave_readable = 1'b0; wave_pos = 5'd9;
    rd(37, "R10"); wr(38, 8'h00, "R10"); wr(36, 8'hEE, "R10");
    wave_playing = 1'b0; rd(38, "R10"); rd(36, "R10"); rd(36 - 32 + 32, "R10");
    // R11 redirect inside window
    wave_playing = 1'b1; wave_readable = 1'b1; wave_pos = 5'd7;
    rd(42, "R11"); wr(47, 8'hC3, "R11"); rd(32, "R11");
    wave_playing = 1'b0; rd(35, "R11"); rd(47, "R11");
    // R12 non-legacy while playing
    legacy_mode = 1'b0; wave_playing = 1'b1; wave_readable = 1'b0; wave_pos = 5'd20;
    rd(33, "R12"); wr(33, 8'h11, "R12"); rd(40, "R12");
    wave_playing = 1'b0; rd(33, "R12"); rd(42, "R12");
    cyc(1'b0, 1'b0, 0, 8'h00, "R13");
    finish_run();
  end
endmodule